// File: doc/BRIEF.md
# Soft-Switch Floppy Controller Register Front End

This block is the register face of a floppy disk controller whose registers are not chosen by a plain address decode. Instead, the controller keeps eight one-bit switches. Every bus access changes one of them, whether it is a read or a write. The low address bits name the switch and say whether it is set or cleared. Two of the switches then decide which internal register the same access reaches: the data port, the status port, the write-handshake port or the mode register.

Software drives the block through a byte-wide register bus. The bus has a 4-bit index, separate read and write strobes and one data byte in each direction. The full switch vector is also brought out, so that nearby drive-select and head-phase logic can decode it. The serial disk data path is not part of this block. Because of that, the data port reads as all ones.

Top module: `floppy_switch_regs`

## Requirements
- R1: After reset all eight switches, the mode register and the handshake register are zero.
- R2: On a cycle where `acc_rd` or `acc_wr` is high, switch number `acc_idx[3:1]` takes the value `acc_idx[0]` at the clock edge, and no other switch changes. The switch numbers are: 0 to 2 head phases, 3 strobe, 4 enable, 5 drive select, 6 low register select, 7 high register select.
- R3: A read at an odd index returns 8'hFF.
- R4: An even-index read with high select 0 and low select 0 returns the data port, which reads 8'hFF.
- R5: An even-index read with high select 0 and low select 1 returns status. Bits [4:0] are the mode register, bit 5 is the enable switch, and bits [7:6] are 0.
- R6: An even-index read with high select 1 and low select 0 returns the handshake register ORed with 8'h3F.
- R7: A write with both selects 1 and enable 0 loads the mode register from `wdata[4:0]`. The handshake register does not change.
- R8: A write with both selects 1 and enable 1 clears bit 7 of the handshake register. The mode register does not change.
- R9: An even-index read with both selects 1 returns 8'hFF and holds `illegal_o` high for that cycle only. `illegal_o` is low on every other cycle.
- R10: The switch change of an access counts before register selection. The read data, `illegal_o` and the write target are all decided from the switch values with that access's own change applied.
- R11: With no strobe active, `rdata` is 8'hFF and the switches, mode and handshake keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_idx | input | 4 | Register index; bits [3:1] name a switch, bit 0 is the value it takes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| illegal_o | output | 1 | Read reached the unassigned select combination |
| latch_o | output | 8 | Registered switch vector |

## Verification
`rdata` and `illegal_o` are due in the same cycle as the strobe. They are computed from the switch values with that access's own change applied. The bench therefore samples them 2 ns before the rising edge that ends the access. `latch_o` and the effect of a write on mode and handshake appear one edge later. The bench checks the switch vector 1 ns after that edge. It checks mode and handshake through the status or handshake read of a later access. The reference model is updated at the same edge, so each comparison lines up with the cycle in which the design's value is due.

// File: rtl/floppy_switch_regs.sv
module floppy_switch_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_rd,
  input  logic       acc_wr,
  input  logic [3:0] acc_idx,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       illegal_o,
  output logic [7:0] latch_o
);
  localparam int SW_ENABLE = 4;
  localparam int SEL_LO    = 6;
  localparam int SEL_HI    = 7;

  logic [7:0] sw_q, sw_nx, mode_q, hs_q;
  logic [1:0] sel;
  logic       acc;

  assign acc = acc_rd | acc_wr;

  always_comb begin
    sw_nx = sw_q;
    if (acc) sw_nx[acc_idx[3:1]] = acc_idx[0];
  end

  assign sel = {sw_nx[SEL_HI], sw_nx[SEL_LO]};

  always_comb begin
    rdata = 8'hFF;
    if (acc_rd && !acc_idx[0]) begin
      case (sel)
        2'b01:   rdata = {2'b00, sw_nx[SW_ENABLE], 5'b0} | (mode_q & 8'h1F);
        2'b10:   rdata = hs_q | 8'h3F;
        default: rdata = 8'hFF;
      endcase
    end
  end

  assign illegal_o = acc_rd && !acc_idx[0] && (sel == 2'b11);
  assign latch_o   = sw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q   <= '0;
      mode_q <= '0;
      hs_q   <= '0;
    end else begin
      sw_q <= sw_nx;
      if (acc_wr && sel == 2'b11) begin
        if (sw_nx[SW_ENABLE]) hs_q[7] <= 1'b0;
        else                  mode_q  <= wdata & 8'h1F;
      end
    end
  end
endmodule

module floppy_switch_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_rd,
  input logic       acc_wr,
  input logic [3:0] acc_idx,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       illegal_o,
  input logic [7:0] latch_o
);
  AST_SWITCH_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd || acc_wr) |=> latch_o[$past(acc_idx[3:1])] == $past(acc_idx[0])); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd || acc_wr) |=> $stable(latch_o)); // R11
  AST_IDLE_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |-> rdata == 8'hFF); // R11
  AST_ODD_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_idx[0]) |-> rdata == 8'hFF); // R3
  AST_ILLEGAL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> rdata == 8'hFF); // R9
  AST_ILLEGAL_ONLY_EVEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (acc_rd && !acc_idx[0])); // R9
  AST_ILLEGAL_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> (latch_o[7] && latch_o[6])); // R10
  AST_STATUS_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_idx[0] && !illegal_o && rdata != 8'hFF && rdata[5:0] != 6'h3F)
      |-> rdata[7:6] == 2'b00); // R5
endmodule

bind floppy_switch_regs floppy_switch_regs_chk u_chk (.*);

// File: tb/floppy_switch_regs_tb.sv
module floppy_switch_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_rd = 1'b0, acc_wr = 1'b0;
  logic [3:0] acc_idx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, latch_o;
  logic       illegal_o;

  int n_cmp = 0, n_bad = 0;
  bit   done = 0;
  bit [7:0] m_sw = '0;
  int   m_mode = 0, m_hs = 0;

  always #4 clk = ~clk;

  floppy_switch_regs u_dut (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_idx(acc_idx), .wdata(wdata), .rdata(rdata),
    .illegal_o(illegal_o), .latch_o(latch_o));

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic access(bit rd, bit wr, int idx, int dat);
    bit [7:0] nx;
    int exp_rd, exp_il;
    string tag;
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_idx = 4'(idx); wdata = 8'(dat);
    nx = m_sw;
    if (rd || wr) nx[(idx >> 1) & 7] = idx[0];
    exp_rd = 255; exp_il = 0;
    tag = "R11";
    if (rd) begin
      if (idx % 2 == 1) tag = "R3";
      else if (!nx[7] && !nx[6]) tag = "R4";
      else if (!nx[7] && nx[6]) begin tag = "R5"; exp_rd = (nx[4] ? 32 : 0) + m_mode; end
      else if (nx[7] && !nx[6]) begin tag = "R6"; exp_rd = 63 + m_hs; end
      else begin tag = "R9"; exp_il = 1; end
    end
    #2;
    check({tag, " rdata"}, int'(rdata), exp_rd);
    check("R9 illegal flag", int'(illegal_o), exp_il);
    @(posedge clk);
    if (wr && nx[7] && nx[6]) begin
      if (nx[4]) m_hs = m_hs & 127;
      else m_mode = dat & 31;
    end
    m_sw = nx;
    #1;
    check("R2 switch vector", int'(latch_o), int'(m_sw));
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R1 switches after reset", int'(latch_o), 0);
    check("R11 idle rdata", int'(rdata), 255);
    access(1, 0, 4'h0, 0);         // R4 data port
    access(1, 0, 4'hD, 0);         // R3 odd read sets low select
    access(1, 0, 4'h0, 0);         // R1 R5 status zero after reset
    access(1, 0, 4'h9, 0);         // enable on
    access(1, 0, 4'h0, 0);         // R5 enable bit
    access(0, 1, 4'h8, 8'hFF);     // enable off, no register written
    access(0, 1, 4'hF, 8'hF5);     // R10 R7 own switch change selects mode
    access(1, 0, 4'hE, 0);         // R10 R5 status shows 0x15
    access(1, 0, 4'hF, 0);         // R3
    access(1, 0, 4'h0, 0);         // R9 illegal combination
    access(1, 0, 4'hC, 0);         // R6 handshake
    access(0, 1, 4'h9, 0);
    access(0, 1, 4'hD, 8'h0A);     // R8 clears handshake bit, mode kept
    access(1, 0, 4'hC, 0);         // R6
    access(1, 0, 4'hD, 0);
    access(1, 0, 4'hE, 0);         // R8 mode still 0x15
    repeat (4) access(0, 0, 4'hF, 8'h55); // R11 idle
    for (int k = 0; k < 96; k++)
      access(k % 3 != 0, k % 3 == 0, (k * 7 + 3) % 16, (k * 37) % 256);
    for (int k = 0; k < 32; k++)
      access(k % 2 == 0, k % 2 == 1, k % 16, 255 - k);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule